// File: doc/BRIEF.md
# Packed SIMD Barrel Shifter

This block shifts a 64-bit word that holds packed elements. One control word picks the element size (16, 32 or 64 bits) and the shift kind (logical left, logical right or arithmetic right). A single shift count applies to every element. Each element is shifted on its own: bits never pass from one element into the next, and the vacated positions take zeros or the element's own sign bit.

The datapath is one right-shifting barrel of log2(width) stages. A left shift reverses the bit order before the barrel and again after it. Each stage has an extra multiplexer per bit. For the selected element size, that multiplexer swaps in the fill bit wherever the source bit would come from across an element boundary. A count at or beyond the element width bypasses the barrel and returns the fill pattern directly. The unit is purely combinational: the result follows the inputs in the same cycle.

Top module: `pk_shift`

## Requirements
- R1: Logical left shift (op code 2'b00) moves every element toward its MSB by the count and fills the vacated low positions with zeros.
- R2: Logical right shift (op code 2'b01) moves every element toward its LSB by the count and fills the vacated high positions with zeros.
- R3: Arithmetic right shift (op code 2'b11) moves every element toward its LSB by the count and fills the vacated high positions with copies of that element's own MSB.
- R4: Size code 2'b00 selects four 16-bit elements and 2'b01 selects two 32-bit elements. Both 2'b10 and 2'b11 select one 64-bit element.
- R5: One 7-bit count applies to all elements. Op code 2'b10 behaves exactly like the logical left shift.
- R6: A count equal to or above the element width gives all zeros for the logical shifts. For the arithmetic right shift it gives every bit equal to the element's sign.
- R7: No bit shifted out of an element appears in a neighbouring element, for any size, op or count.
- R8: A count of zero returns the source unchanged for every op and size.
- R9: The result is a combinational function of the present inputs. All-zero inputs give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Shift kind: 00/10 logical left, 01 logical right, 11 arithmetic right |
| size_i | input | 2 | Element size: 00 16-bit, 01 32-bit, 10/11 64-bit |
| cnt_i | input | 7 | Shift count shared by all elements (0 to 127) |
| src_i | input | 64 | Packed source operand |
| res_o | output | 64 | Packed shifted result |

## Verification
The hardest case to reach is the seam between elements. There, a stage's boundary multiplexer must choose fill instead of the neighbour's bit. This shows only when a lane's top or bottom bits are non-zero and the neighbouring lane carries a different pattern and sign. Directed sweeps run every count from 0 to 70 for every size and op code. They use alternating patterns, all-ones words and words whose lane signs differ, so each boundary mux and the saturation bypass are driven on both sides. Random operands with random counts then cover mixed patterns across the same space.

// File: rtl/pk_shift_pkg.sv
package pk_shift_pkg;

   typedef enum logic [1:0] {
      SH_LSL     = 2'b00,
      SH_LSR     = 2'b01,
      SH_LSL_ALT = 2'b10,
      SH_ASR     = 2'b11
   } sh_op_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pk_shift_ctrl.sv
module pk_shift_ctrl #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned MIN_LANE  = 16,
   parameter int unsigned NUM_SIZES = 3,
   parameter int unsigned CNT_W     = 7,
   parameter int unsigned SZ_W      = 2
) (
   input  logic [1:0]        op_i,
   input  logic [SZ_W-1:0]   size_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [DATA_W-1:0] src_i,
   output logic              go_left_o,
   output logic [SZ_W-1:0]   sz_idx_o,
   output logic              sat_o,
   output logic [DATA_W-1:0] fill_o
);
   import pk_shift_pkg::*;

   localparam logic [SZ_W-1:0] LAST_SZ = SZ_W'(NUM_SIZES - 1);

   // Copy of each lane's MSB spread over the whole lane
   function automatic logic [DATA_W-1:0] spread_sign(input logic [DATA_W-1:0] d,
                                                     input int unsigned lw);
      logic [DATA_W-1:0] r;
      for (int unsigned i = 0; i < DATA_W; i++) begin
         r[i] = d[(i / lw) * lw + lw - 1];
      end
      return r;
   endfunction

   logic [DATA_W-1:0]    fill_z [NUM_SIZES];
   logic [NUM_SIZES-1:0] sat_z;
   logic                 arith;

   for (genvar z = 0; z < NUM_SIZES; z++) begin : g_size
      localparam int unsigned LW = MIN_LANE << z;
      assign fill_z[z] = spread_sign(src_i, LW);
      assign sat_z[z]  = (cnt_i >= CNT_W'(LW));
   end

   assign arith     = (sh_op_e'(op_i) == SH_ASR);
   assign go_left_o = ~op_i[0];
   assign sz_idx_o  = (size_i > LAST_SZ) ? LAST_SZ : size_i;

   always_comb begin
      sat_o  = sat_z[sz_idx_o];
      fill_o = arith ? fill_z[sz_idx_o] : '0;
   end

endmodule

// File: rtl/pk_shift_stage.sv
module pk_shift_stage #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned MIN_LANE  = 16,
   parameter int unsigned NUM_SIZES = 3,
   parameter int unsigned SZ_W      = 2,
   parameter int unsigned STEP      = 1
) (
   input  logic              en_i,
   input  logic [SZ_W-1:0]   sz_idx_i,
   input  logic [DATA_W-1:0] fill_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] d_o
);

   // Bits whose source lies STEP places up, beyond the top of their own lane
   function automatic logic [DATA_W-1:0] seam_mask(input int unsigned lw);
      logic [DATA_W-1:0] m;
      for (int unsigned i = 0; i < DATA_W; i++) begin
         m[i] = ((i % lw) + STEP) >= lw;
      end
      return m;
   endfunction

   logic [DATA_W-1:0] xm [NUM_SIZES];
   logic [DATA_W-1:0] shv;
   logic [DATA_W-1:0] sel_xm;

   for (genvar z = 0; z < NUM_SIZES; z++) begin : g_mask
      localparam logic [DATA_W-1:0] XMZ = seam_mask(MIN_LANE << z);
      assign xm[z] = XMZ;
   end

   assign shv    = d_i >> STEP;
   assign sel_xm = xm[sz_idx_i];

   always_comb begin
      if (en_i) begin
         for (int unsigned i = 0; i < DATA_W; i++) begin
            d_o[i] = sel_xm[i] ? fill_i[i] : shv[i];
         end
      end else begin
         d_o = d_i;
      end
   end

endmodule

// File: rtl/pk_shift.sv
module pk_shift #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned MIN_LANE  = 16,
   parameter int unsigned NUM_SIZES = 3,
   localparam int unsigned STAGES   = $clog2(DATA_W),
   localparam int unsigned CNT_W    = STAGES + 1,
   localparam int unsigned SZ_W     = (NUM_SIZES > 1) ? $clog2(NUM_SIZES + 1) : 1
) (
   input  logic [1:0]        op_i,
   input  logic [SZ_W-1:0]   size_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [DATA_W-1:0] src_i,
   output logic [DATA_W-1:0] res_o
);
   import pk_shift_pkg::*;

   if (!is_pow2(DATA_W)) begin : g_bad_width
      $error("pk_shift: DATA_W must be a power of two");
   end
   if (!is_pow2(MIN_LANE) || MIN_LANE < 2) begin : g_bad_lane
      $error("pk_shift: MIN_LANE must be a power of two of at least 2");
   end
   if (NUM_SIZES < 1 || (MIN_LANE << (NUM_SIZES - 1)) > DATA_W) begin : g_bad_sizes
      $error("pk_shift: widest lane must fit in DATA_W");
   end

   function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] d);
      logic [DATA_W-1:0] r;
      for (int unsigned i = 0; i < DATA_W; i++) begin
         r[i] = d[DATA_W-1-i];
      end
      return r;
   endfunction

   logic              go_left;
   logic [SZ_W-1:0]   sz_idx;
   logic              sat;
   logic [DATA_W-1:0] fill;
   logic [DATA_W-1:0] chain [STAGES+1];
   logic [DATA_W-1:0] right_res;

   pk_shift_ctrl #(
      .DATA_W(DATA_W), .MIN_LANE(MIN_LANE), .NUM_SIZES(NUM_SIZES),
      .CNT_W(CNT_W), .SZ_W(SZ_W)
   ) u_ctrl (
      .op_i(op_i), .size_i(size_i), .cnt_i(cnt_i), .src_i(src_i),
      .go_left_o(go_left), .sz_idx_o(sz_idx), .sat_o(sat), .fill_o(fill)
   );

   // Lanes are aligned powers of two, so bit reversal maps each lane onto a lane
   assign chain[0] = go_left ? flip(src_i) : src_i;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      pk_shift_stage #(
         .DATA_W(DATA_W), .MIN_LANE(MIN_LANE), .NUM_SIZES(NUM_SIZES),
         .SZ_W(SZ_W), .STEP(1 << k)
      ) u_stage (
         .en_i(cnt_i[k]), .sz_idx_i(sz_idx), .fill_i(fill),
         .d_i(chain[k]), .d_o(chain[k+1])
      );
   end

   assign right_res = sat ? fill : chain[STAGES];
   assign res_o     = go_left ? flip(right_res) : right_res;

endmodule

// File: rtl/pk_shift_chk.sv
module pk_shift_chk #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned MIN_LANE  = 16,
   parameter int unsigned NUM_SIZES = 3,
   parameter int unsigned CNT_W     = 7,
   parameter int unsigned SZ_W      = 2
) (
   input logic [1:0]        op_i,
   input logic [SZ_W-1:0]   size_i,
   input logic [CNT_W-1:0]  cnt_i,
   input logic [DATA_W-1:0] src_i,
   input logic [DATA_W-1:0] res_o
);
   int unsigned lw;
   logic        msb_kept, msb_clear, lsb_clear;

   always_comb begin
      lw = (int'(size_i) >= NUM_SIZES) ? (MIN_LANE << (NUM_SIZES - 1))
                                       : (MIN_LANE << size_i);
      msb_kept  = 1'b1;
      msb_clear = 1'b1;
      lsb_clear = 1'b1;
      for (int unsigned i = 0; i < DATA_W; i++) begin
         if (((i + 1) % lw) == 0) begin
            if (res_o[i] != src_i[i]) msb_kept = 1'b0;
            if (res_o[i]) msb_clear = 1'b0;
         end
         if ((i % lw) == 0 && res_o[i]) lsb_clear = 1'b0;
      end
   end

   always_comb begin
      // R8: zero count is identity
      p_identity_r8: assert (cnt_i != '0 || res_o == src_i)
         else $error("zero count changed data");
      // R6: logical shifts saturate to zero
      p_sat_zero_r6: assert (op_i == 2'b11 || int'(cnt_i) < lw || res_o == '0)
         else $error("logical shift past lane width not zero");
      // R3: arithmetic right keeps each lane's sign
      p_sign_kept_r3: assert (op_i != 2'b11 || msb_kept)
         else $error("lane sign lost");
      // R2: logical right clears each lane MSB
      p_msb_clear_r2: assert (op_i != 2'b01 || cnt_i == '0 || msb_clear)
         else $error("lane MSB not cleared");
      // R1: logical left clears each lane LSB
      p_lsb_clear_r1: assert (op_i[0] || cnt_i == '0 || lsb_clear)
         else $error("lane LSB not cleared");
   end

endmodule

bind pk_shift pk_shift_chk u_chk (
   .op_i(op_i), .size_i(size_i), .cnt_i(cnt_i), .src_i(src_i), .res_o(res_o)
);

// File: tb/pk_shift_test.sv
module pk_shift_test;

   logic        clk = 1'b0;
   logic [1:0]  op;
   logic [1:0]  size;
   logic [6:0]  cnt;
   logic [63:0] src;
   logic [63:0] res;

   int vectors  = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   pk_shift uut (.op_i(op), .size_i(size), .cnt_i(cnt), .src_i(src), .res_o(res));

   function automatic logic [63:0] model(input logic [1:0] o, input logic [1:0] s,
                                         input int c, input logic [63:0] d);
      logic [63:0] r;
      int lw;
      lw = (s == 2'd0) ? 16 : (s == 2'd1) ? 32 : 64;
      for (int i = 0; i < 64; i++) begin
         int base, pos, p;
         logic fb;
         base = (i / lw) * lw;
         pos  = i - base;
         fb   = (o == 2'b11) ? d[base + lw - 1] : 1'b0;
         if (!o[0]) begin
            r[i] = (c <= pos) ? d[i - c] : 1'b0;
         end else begin
            p    = pos + c;
            r[i] = (p < lw) ? d[base + p] : fb;
         end
      end
      return r;
   endfunction

   function automatic string tag_of(input logic [1:0] o, input logic [1:0] s, input int c);
      int lw;
      lw = (s == 2'd0) ? 16 : (s == 2'd1) ? 32 : 64;
      if (c == 0)        return "R8";
      if (c >= lw)       return "R6";
      if (s == 2'd3)     return "R4";
      if (o == 2'b10)    return "R5";
      if (o == 2'b00)    return "R1";
      if (o == 2'b01)    return "R2";
      return "R3";
   endfunction

   task automatic apply(input logic [1:0] o, input logic [1:0] s, input int c,
                        input logic [63:0] d, input string tag);
      logic [63:0] exp;
      @(negedge clk);
      op = o; size = s; cnt = 7'(c); src = d;
      #1;
      exp = model(o, s, c, d);
      vectors++;
      if (res !== exp) begin
         failures++;
         $display("FAIL %s op=%b size=%b cnt=%0d src=%h got %h expected %h",
                  tag, o, s, c, d, res, exp);
      end
   endtask

   initial begin
      logic [63:0] pats [4];
      void'($urandom(32'd20240611));
      op = '0; size = '0; cnt = '0; src = '0;
      apply(2'b00, 2'b00, 0, 64'h0, "R9");   // all-zero inputs give zero
      pats[0] = 64'hAAAA_5555_AAAA_5555;
      pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[2] = 64'h8001_7FFE_8000_0001;
      pats[3] = 64'h7FFF_8000_0000_FFFF;
      // Directed sweep: every size, op and count 0..70 (R4, R5, R6, R7)
      for (int s = 0; s < 4; s++)
         for (int o = 0; o < 4; o++)
            for (int c = 0; c <= 70; c++)
               for (int p = 0; p < 4; p++)
                  apply(2'(o), 2'(s), c, pats[p],
                        (p == 1) ? "R7" : tag_of(2'(o), 2'(s), c));
      // R5: same count reaches every lane, counts up to 127
      apply(2'b01, 2'b00, 127, 64'hFFFF_0000_FFFF_0000, "R5");
      apply(2'b11, 2'b01, 127, 64'h8000_0000_7FFF_FFFF, "R6");
      // R9: result follows a change within the same cycle
      apply(2'b11, 2'b00, 4, 64'h8000_8000_0000_8000, "R9");
      // Random operands
      for (int n = 0; n < 3000; n++) begin
         logic [1:0] o, s;
         int c;
         o = 2'($urandom_range(0, 3));
         s = 2'($urandom_range(0, 3));
         c = $urandom_range(0, 80);
         apply(o, s, c, {$urandom(), $urandom()}, tag_of(o, s, c));
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
         $finish;
      end
   end

endmodule